// File: doc/BRIEF.md
# Interlocked Read Handshake Link

This block pairs two handshake state machines that carry out a single-word read over a narrow shared bus, without relying on a common clock between the two parties. A requester side accepts a read request with an address, places the address on a shared address/data bus and walks a fully interlocked four-phase exchange with a responder side. The responder captures the address, answers from a small internal word array, and returns the word over the same bus lines. Three control wires carry the exchange. The request line is driven only by the requester. The ready line is driven only by the responder. The acknowledge line is a wired-OR that each side drives in its own phase.

Both sides are built in one clock domain. Every control wire a side reads passes first through a synchronizer chain, as if the two sides ran on unrelated clocks. No step is taken on a timing guess. Each side moves only after it observes the other side's response, and it waits for a released wire to read back low before it proceeds. Because of that rule, stale synchronizer contents can never advance either state machine. The shared bus is modelled with one output enable per side. When neither side drives the bus, it reads zero.

Requester states: `D_IDLE` (waits for a request), `D_ADDR` (drives address and request, waits for acknowledge), `D_WAIT` (bus and request released, waits for ready), `D_ACK` (word captured, acknowledge high, waits for ready low) and `D_SETTLE` (acknowledge low, waits for it to read low). Its transitions are start, addr_taken, data_seen, ready_gone and settled. Responder states: `M_IDLE` (waits for request), `M_ACK` (address latched, acknowledge high, waits for request low), `M_DROP` (word and ready driven, acknowledge low, waits to see acknowledge low), `M_HOLD` (waits for the requester's acknowledge) and `M_FREE` (bus and ready released, waits for acknowledge low). Its transitions are latch, req_gone, ack_clear, ack_seen and freed.

Top module: `rdhs_link`

## Requirements
- R1: While reset is held and on the first cycle after it, busy, done, rd_data, all three control wires and the bus read 0.
- R2: When busy is low and req_valid is high at a clock edge, the next cycle shows busy high, the request wire high and req_addr on the bus.
- R3: The responder raises acknowledge exactly SYNC+1 cycles after the request wire rises. The requester then drops the request wire and stops driving the bus. Until it sees acknowledge, the requester keeps the request wire high.
- R4: Only after seeing the request wire low does the responder raise ready. In that same cycle it lowers its acknowledge and starts to drive the word on the bus. The request wire is never high while ready is high.
- R5: The control wires {request, acknowledge, ready} move through exactly this cycle of values: 000, 100, 110, 010, 001, 011, 010, 000. Each read goes through it once.
- R6: The word returned for address a is entry (a mod DEPTH) of the array. Entry i holds (29*i + 7) mod 2^W.
- R7: At the end of a read, rd_data holds the returned word and done is high for exactly one cycle. busy falls in the same cycle that done rises.
- R8: A req_valid that arrives while busy is high is ignored. It does not change the word returned, and no second read follows.
- R9: The two sides never drive the bus together. In the phases where neither side drives it (request released, ready released, idle), the bus reads 0.
- R10: While ready is high, the bus value stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New read request (taken when not busy) |
| req_addr | input | W | Address of the requested word |
| busy | output | 1 | Requester is not idle |
| done | output | 1 | One-cycle pulse when a read completes |
| rd_data | output | W | Word returned by the last read |
| hs_readreq | output | 1 | Request control wire |
| hs_ack | output | 1 | Acknowledge control wire (wired-OR of both sides) |
| hs_datardy | output | 1 | Ready control wire |
| hs_bus | output | W | Resolved shared address/data bus |

## Verification
The bench builds the block with its default values: an 8-bit bus, a 16-entry array and two synchronizer stages. With a bus wider than the index, addresses with upper bits set are in reach, so the modulo indexing of R6 can be checked directly. Two stages make the acknowledge latency of R3 an exact three cycles that the bench can verify. A wire-level monitor follows every read through the eight-value control cycle and checks the bus contents in each phase. Random addresses are mixed with edge addresses, back-to-back reads and requests issued during a busy read.

// File: rtl/rdhs_pkg.sv
package rdhs_pkg;

    typedef enum logic [2:0] {
        D_IDLE,
        D_ADDR,
        D_WAIT,
        D_ACK,
        D_SETTLE
    } dev_state_t;

    typedef enum logic [2:0] {
        M_IDLE,
        M_ACK,
        M_DROP,
        M_HOLD,
        M_FREE
    } mem_state_t;

    localparam int ROM_MUL = 29;
    localparam int ROM_ADD = 7;

endpackage

// File: rtl/rdhs_sync.sv
module rdhs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= din;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rdhs_dev_fsm.sv
module rdhs_dev_fsm
    import rdhs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic [W-1:0] req_addr,
    input  logic         ack_s,
    input  logic         rdy_s,
    input  logic [W-1:0] bus_in,
    output logic         readreq,
    output logic         ack_o,
    output logic         oe,
    output logic [W-1:0] bus_out,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rd_data
);
    dev_state_t   state_q, state_d;
    logic [W-1:0] addr_q, data_q;
    logic         done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= D_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            D_IDLE:   if (req_valid) state_d = D_ADDR;
            D_ADDR:   if (ack_s)     state_d = D_WAIT;
            D_WAIT:   if (rdy_s)     state_d = D_ACK;
            D_ACK:    if (!rdy_s)    state_d = D_SETTLE;
            D_SETTLE: if (!ack_s)    state_d = D_IDLE;
            default:                 state_d = D_IDLE;
        endcase
    end

    always_comb begin
        readreq = 1'b0;
        oe      = 1'b0;
        ack_o   = 1'b0;
        unique case (state_q)
            D_ADDR: begin readreq = 1'b1; oe = 1'b1; end
            D_ACK:  ack_o = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == D_SETTLE) && !ack_s;
            if (state_q == D_IDLE && req_valid) addr_q <= req_addr;
            if (state_q == D_WAIT && rdy_s)     data_q <= bus_in;
        end
    end

    assign bus_out = addr_q;
    assign busy    = (state_q != D_IDLE);
    assign done    = done_q;
    assign rd_data = data_q;
endmodule

// File: rtl/rdhs_mem_fsm.sv
module rdhs_mem_fsm
    import rdhs_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rr_s,
    input  logic         ack_s,
    input  logic [W-1:0] bus_in,
    output logic         ack_o,
    output logic         datardy,
    output logic         oe,
    output logic [W-1:0] bus_out
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    mem_state_t   state_q, state_d;
    logic [W-1:0] addr_q;
    logic [W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = W'(g * ROM_MUL + ROM_ADD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= M_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M_IDLE: if (rr_s)   state_d = M_ACK;
            M_ACK:  if (!rr_s)  state_d = M_DROP;
            M_DROP: if (!ack_s) state_d = M_HOLD;
            M_HOLD: if (ack_s)  state_d = M_FREE;
            M_FREE: if (!ack_s) state_d = M_IDLE;
            default:            state_d = M_IDLE;
        endcase
    end

    always_comb begin
        ack_o   = 1'b0;
        datardy = 1'b0;
        oe      = 1'b0;
        unique case (state_q)
            M_ACK:          ack_o = 1'b1;
            M_DROP, M_HOLD: begin datardy = 1'b1; oe = 1'b1; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                        addr_q <= '0;
        else if (state_q == M_IDLE && rr_s) addr_q <= bus_in;
    end

    assign bus_out = rom[IW'(32'(addr_q) % DEPTH)];
endmodule

// File: rtl/rdhs_link.sv
module rdhs_link #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int SYNC  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic [W-1:0] req_addr,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rd_data,
    output logic         hs_readreq,
    output logic         hs_ack,
    output logic         hs_datardy,
    output logic [W-1:0] hs_bus
);
    logic         dev_rr, dev_ack, dev_oe;
    logic         mem_ack, mem_dr, mem_oe;
    logic [W-1:0] dev_bus, mem_bus;
    logic         d_ack_s, d_rdy_s, m_rr_s, m_ack_s;

    assign hs_readreq = dev_rr;
    assign hs_ack     = dev_ack | mem_ack;
    assign hs_datardy = mem_dr;
    assign hs_bus     = (dev_oe ? dev_bus : '0) | (mem_oe ? mem_bus : '0);

    rdhs_sync #(.WIDTH(2), .STAGES(SYNC)) u_dev_sync (
        .clk(clk), .rst_n(rst_n),
        .din({hs_ack, hs_datardy}), .dout({d_ack_s, d_rdy_s})
    );

    rdhs_sync #(.WIDTH(2), .STAGES(SYNC)) u_mem_sync (
        .clk(clk), .rst_n(rst_n),
        .din({hs_readreq, hs_ack}), .dout({m_rr_s, m_ack_s})
    );

    rdhs_dev_fsm #(.W(W)) u_dev (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr),
        .ack_s(d_ack_s), .rdy_s(d_rdy_s), .bus_in(hs_bus),
        .readreq(dev_rr), .ack_o(dev_ack), .oe(dev_oe), .bus_out(dev_bus),
        .busy(busy), .done(done), .rd_data(rd_data)
    );

    rdhs_mem_fsm #(.W(W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .rr_s(m_rr_s), .ack_s(m_ack_s), .bus_in(hs_bus),
        .ack_o(mem_ack), .datardy(mem_dr), .oe(mem_oe), .bus_out(mem_bus)
    );
endmodule

// File: rtl/rdhs_link_chk.sv
module rdhs_link_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         dev_oe,
    input logic         mem_oe,
    input logic         readreq,
    input logic         ack,
    input logic         datardy,
    input logic [W-1:0] bus,
    input logic         busy,
    input logic         done
);
    AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_oe && mem_oe)); // R9

    AST_RDY_AFTER_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        datardy |-> !readreq); // R4

    AST_REQ_HELD_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (readreq && !ack) |=> readreq); // R3

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !readreq); // R8

    AST_BUS_STABLE_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (datardy && $past(datardy)) |-> $stable(bus)); // R10

    AST_RDY_HELD_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (datardy && !ack) |=> datardy); // R5
endmodule

bind rdhs_link rdhs_link_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dev_oe(dev_oe), .mem_oe(mem_oe),
    .readreq(hs_readreq), .ack(hs_ack), .datardy(hs_datardy),
    .bus(hs_bus), .busy(busy), .done(done)
);

// File: tb/rdhs_link_bench.sv
module rdhs_link_bench;
    localparam int W     = 8;
    localparam int DEPTH = 16;
    localparam int SYNC  = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [W-1:0] req_addr = '0;
    logic         busy, done, hs_readreq, hs_ack, hs_datardy;
    logic [W-1:0] rd_data, hs_bus;

    int checks = 0;
    int errors = 0;
    int issued = 0;
    int mon_txn = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    rdhs_link #(.W(W), .DEPTH(DEPTH), .SYNC(SYNC)) u_rdhs_link (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy), .done(done), .rd_data(rd_data),
        .hs_readreq(hs_readreq), .hs_ack(hs_ack), .hs_datardy(hs_datardy),
        .hs_bus(hs_bus)
    );

    function automatic logic [W-1:0] exp_word(input logic [W-1:0] a);
        int idx;
        idx = int'(a) % DEPTH;
        return W'(idx * 29 + 7);
    endfunction

    function automatic logic [2:0] ph_bits(input int p);
        case (p)
            0: return 3'b000;
            1: return 3'b100;
            2: return 3'b110;
            3: return 3'b010;
            4: return 3'b001;
            5: return 3'b011;
            default: return 3'b010;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // wire-level monitor of the control cycle
    int           ph = 0;
    int           rr_cyc = 0;
    logic [W-1:0] mon_addr = '0;
    always @(negedge clk) begin
        logic [2:0] cur;
        int nxt;
        cur = {hs_readreq, hs_ack, hs_datardy};
        nxt = (ph + 1) % 7;
        if (rst_n) begin
            if (cur == ph_bits(ph)) begin
                if (ph == 1) rr_cyc++;
            end else if (cur == ph_bits(nxt)) begin
                case (nxt)
                    1: begin mon_addr = hs_bus; rr_cyc = 1; end
                    2: chk(rr_cyc == SYNC + 1, "R3 ack latency", rr_cyc, SYNC + 1);
                    3: chk(hs_bus == '0, "R9 bus idle after request drop", hs_bus, 0);
                    4: chk(hs_bus == exp_word(mon_addr), "R4 R6 word on bus",
                           hs_bus, exp_word(mon_addr));
                    6: chk(hs_bus == '0, "R9 bus idle after ready drop", hs_bus, 0);
                    0: mon_txn++;
                    default: ;
                endcase
                ph = nxt;
            end else begin
                chk(1'b0, "R5 control sequence", cur, ph_bits(nxt));
                ph = 0;
            end
        end
    end

    task automatic do_read(input logic [W-1:0] a, input bit poke, input logic [W-1:0] a2);
        int wait_n;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        issued++;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R2 busy after request", busy, 1);
        chk(hs_readreq == 1'b1, "R2 request wire", hs_readreq, 1);
        chk(hs_bus == a, "R2 address on bus", hs_bus, a);
        if (poke) begin
            repeat (4) @(negedge clk);
            req_valid = 1'b1;
            req_addr  = a2;
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait_n = 0;
        while (!done && wait_n < 400) begin
            @(negedge clk);
            wait_n++;
        end
        chk(done == 1'b1, "R7 done seen", done, 1);
        chk(rd_data == exp_word(a), "R6 R7 read data", rd_data, exp_word(a));
        chk(busy == 1'b0, "R7 busy falls with done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", done, 0);
        if (poke) begin
            int saw_rr;
            saw_rr = 0;
            for (int i = 0; i < 12; i++) begin
                if (hs_readreq || busy) saw_rr++;
                @(negedge clk);
            end
            chk(saw_rr == 0, "R8 no second read", saw_rr, 0);
            chk(rd_data == exp_word(a), "R8 data unchanged", rd_data, exp_word(a));
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        chk({busy, done, hs_readreq, hs_ack, hs_datardy} == 5'b0, "R1 reset outputs",
            {busy, done, hs_readreq, hs_ack, hs_datardy}, 0);
        chk(rd_data == '0 && hs_bus == '0, "R1 reset data", {rd_data, hs_bus}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, hs_readreq, hs_ack, hs_datardy} == 5'b0, "R1 after reset",
            {busy, done, hs_readreq, hs_ack, hs_datardy}, 0);
        chk(hs_bus == '0, "R9 bus idle", hs_bus, 0);

        do_read(8'h00, 1'b0, '0);
        do_read(8'h0F, 1'b0, '0);
        do_read(8'hFF, 1'b0, '0);
        do_read(8'h93, 1'b1, 8'h05);
        do_read(8'h05, 1'b0, '0);
        for (int k = 0; k < 40; k++) begin
            logic [W-1:0] a;
            a = W'($urandom);
            do_read(a, ($urandom % 5) == 0, W'($urandom));
        end
        repeat (10) @(negedge clk);
        chk(mon_txn == issued, "R5 one control cycle per read", mon_txn, issued);
        chk(ph == 0, "R5 cycle closed", ph, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end
endmodule